// File: doc/BRIEF.md
# Display-First Microsecond Bus Slot Arbiter

This block sits between a display fetch engine and a CPU that share one memory. It runs entirely from a single master clock, nominally 16 MHz, and divides time into repeating slots of `SLOT_TICKS` master ticks, which is 1 µs at the default. The first half of every slot always belongs to the display fetch. The second half is the CPU's access window. The block also produces a CPU clock enable at the master rate divided by `CPU_DIV`.

When the CPU raises a memory or I/O request (`mreq_n` or `iorq_n` low) during the display half, `ready` drops. `ready` drives the CPU's active-low WAIT pin. It stays low until the CPU window opens. Every access finishes on the last tick of a slot, so each instruction lasts a whole number of slots, whatever phase its request starts in. The CPU can be clocked at 4 MHz and still sustain only about 3.3 MHz of useful throughput.

For the display side, the block keeps a slot-within-line counter and a line counter. At the defaults, a line is 64 slots (64 µs) and a frame is 312 lines, which gives 19968 µs per frame at 50 Hz.

Top module: `vid_wait_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the slot phase, line slot and line number outputs are cleared to 0. `ready` stays high during reset even if a request is present.
- R2: `slot_phase` advances by one on every master tick. It wraps from `SLOT_TICKS-1` (default 16 ticks per slot) to 0.
- R3: `cpu_clk_en` is high exactly on ticks whose slot phase is a multiple of `CPU_DIV` (default 4). This gives `SLOT_TICKS/CPU_DIV` CPU clocks per slot.
- R4: `vid_fetch` is high for slot phases 0 to `SLOT_TICKS/2-1` and low otherwise, whatever the CPU is doing.
- R5: `ready` is low exactly when a request (`mreq_n` low or `iorq_n` low) is present and the slot phase is below `SLOT_TICKS/2`. A request that first appears at phase s < `SLOT_TICKS/2` therefore sees `SLOT_TICKS/2 - s` wait ticks, and a request inside the window sees none.
- R6: `cpu_done` is high only on a tick with slot phase `SLOT_TICKS-1` while a request is present. A request held from phase s completes after `SLOT_TICKS - s` ticks, counting its first tick.
- R7: `line_slot` advances at the end of each slot and wraps after `LINE_SLOTS-1` (default 64). `line_strobe` is high on the last tick of the last slot of a line.
- R8: `line_num` advances at the end of each line and wraps after `FRAME_LINES-1` (default 312). `frame_strobe` is high on the last tick of the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mreq_n | input | 1 | CPU memory request, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| ready | output | 1 | High lets the CPU proceed; drives its WAIT pin |
| cpu_clk_en | output | 1 | CPU clock enable |
| vid_fetch | output | 1 | Display owns the memory this tick |
| cpu_done | output | 1 | CPU access completes this tick |
| slot_phase | output | $clog2(SLOT_TICKS) | Tick position inside the slot |
| line_slot | output | $clog2(LINE_SLOTS) | Slot position inside the line |
| line_num | output | $clog2(FRAME_LINES) | Line position inside the frame |
| line_strobe | output | 1 | Last tick of a line |
| frame_strobe | output | 1 | Last tick of a frame |

## Verification
The bench keeps `SLOT_TICKS=16` and `CPU_DIV=4`, so the slot phase map and the wait counts are exactly those of the real timing. It shrinks `LINE_SLOTS` to 4 and `FRAME_LINES` to 5, so that several complete line and frame wraps fit in a short run. Memory and I/O requests, and both together, start at every one of the 16 phases. The wait length and the completion tick of each one are compared against values predicted from its starting phase, while the display fetch pattern is checked on every tick.

// File: rtl/vid_wait_gen.sv
module vid_wait_gen #(
  parameter int SLOT_TICKS  = 16,
  parameter int CPU_DIV     = 4,
  parameter int LINE_SLOTS  = 64,
  parameter int FRAME_LINES = 312
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           mreq_n,
  input  logic                           iorq_n,
  output logic                           ready,
  output logic                           cpu_clk_en,
  output logic                           vid_fetch,
  output logic                           cpu_done,
  output logic [$clog2(SLOT_TICKS)-1:0]  slot_phase,
  output logic [$clog2(LINE_SLOTS)-1:0]  line_slot,
  output logic [$clog2(FRAME_LINES)-1:0] line_num,
  output logic                           line_strobe,
  output logic                           frame_strobe
);
  localparam int PW   = $clog2(SLOT_TICKS);
  localparam int SW   = $clog2(LINE_SLOTS);
  localparam int LW   = $clog2(FRAME_LINES);
  localparam int HALF = SLOT_TICKS / 2;
  localparam logic [PW-1:0] PH_LAST   = PW'(SLOT_TICKS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(LINE_SLOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(FRAME_LINES - 1);

  logic [PW-1:0] phase;
  logic [SW-1:0] col;
  logic [LW-1:0] row;
  logic          slot_end, line_end, frame_end, cpu_req;

  assign slot_end  = (phase == PH_LAST);
  assign line_end  = slot_end && (col == SLOT_LAST);
  assign frame_end = line_end && (row == LINE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      col   <= '0;
      row   <= '0;
    end else begin
      phase <= slot_end ? '0 : phase + 1'b1;
      if (slot_end)
        col <= line_end ? '0 : col + 1'b1;
      if (line_end)
        row <= frame_end ? '0 : row + 1'b1;
    end
  end

  assign cpu_req      = !mreq_n || !iorq_n;
  assign vid_fetch    = (32'(phase) < HALF);
  assign cpu_clk_en   = ((32'(phase) % CPU_DIV) == 0);
  assign ready        = rst || !(cpu_req && vid_fetch);
  assign cpu_done     = !rst && cpu_req && slot_end;
  assign slot_phase   = phase;
  assign line_slot    = col;
  assign line_num     = row;
  assign line_strobe  = line_end;
  assign frame_strobe = frame_end;
endmodule

// File: rtl/vid_wait_gen_chk.sv
module vid_wait_gen_chk #(
  parameter int SLOT_TICKS  = 16,
  parameter int CPU_DIV     = 4,
  parameter int LINE_SLOTS  = 64,
  parameter int FRAME_LINES = 312
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           mreq_n,
  input logic                           iorq_n,
  input logic                           ready,
  input logic                           cpu_clk_en,
  input logic                           vid_fetch,
  input logic                           cpu_done,
  input logic [$clog2(SLOT_TICKS)-1:0]  slot_phase,
  input logic [$clog2(LINE_SLOTS)-1:0]  line_slot,
  input logic [$clog2(FRAME_LINES)-1:0] line_num,
  input logic                           line_strobe,
  input logic                           frame_strobe
);
  localparam int PW = $clog2(SLOT_TICKS);
  localparam logic [PW-1:0] PH_LAST = PW'(SLOT_TICKS - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(SLOT_TICKS / 2);

  a_r1_ready_in_reset: assert property (@(posedge clk) rst |-> ready);

  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    (slot_phase != PH_LAST) |=> (slot_phase == PW'($past(slot_phase) + 1'b1)));

  a_r3_slot_opens_cpu_clk: assert property (@(posedge clk) disable iff (rst)
    (slot_phase == '0) |-> cpu_clk_en);

  a_r4_fetch_ends_mid_slot: assert property (@(posedge clk) disable iff (rst)
    $fell(vid_fetch) |-> (slot_phase == PH_HALF));

  a_r5_no_wait_in_window: assert property (@(posedge clk) disable iff (rst)
    !vid_fetch |-> ready);

  a_r5_idle_never_waits: assert property (@(posedge clk) disable iff (rst)
    (mreq_n && iorq_n) |-> ready);

  a_r6_done_on_boundary: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> (slot_phase == '0));

  a_r6_done_not_stalled: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> ready && !vid_fetch);

  a_r7_line_restart: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> (line_slot == '0) && (slot_phase == '0));

  a_r8_frame_restart: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> (line_num == '0) && (line_slot == '0));

  a_r8_frame_implies_line: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> line_strobe);
endmodule

bind vid_wait_gen vid_wait_gen_chk #(
  .SLOT_TICKS(SLOT_TICKS), .CPU_DIV(CPU_DIV),
  .LINE_SLOTS(LINE_SLOTS), .FRAME_LINES(FRAME_LINES)
) u_chk (
  .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .ready(ready),
  .cpu_clk_en(cpu_clk_en), .vid_fetch(vid_fetch), .cpu_done(cpu_done),
  .slot_phase(slot_phase), .line_slot(line_slot), .line_num(line_num),
  .line_strobe(line_strobe), .frame_strobe(frame_strobe)
);

// File: tb/test_vid_wait_gen.sv
module test_vid_wait_gen;
  localparam int ST = 16, CD = 4, LS = 4, FL = 5;
  localparam int HALF = ST / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mreq_n = 1'b1, iorq_n = 1'b1;
  logic ready, cpu_clk_en, vid_fetch, cpu_done, line_strobe, frame_strobe;
  logic [$clog2(ST)-1:0] slot_phase;
  logic [$clog2(LS)-1:0] line_slot;
  logic [$clog2(FL)-1:0] line_num;

  vid_wait_gen #(.SLOT_TICKS(ST), .CPU_DIV(CD), .LINE_SLOTS(LS), .FRAME_LINES(FL)) i_vid_wait_gen (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .ready(ready),
    .cpu_clk_en(cpu_clk_en), .vid_fetch(vid_fetch), .cpu_done(cpu_done),
    .slot_phase(slot_phase), .line_slot(line_slot), .line_num(line_num),
    .line_strobe(line_strobe), .frame_strobe(frame_strobe));

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int cnt = 0;
  int lines_seen = 0, frames_seen = 0;
  bit finished = 0;

  typedef struct { int ticks; int waits; } exp_t;
  exp_t q[$];

  always @(posedge clk) cnt <= rst ? 0 : cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: samples 1 ns after the falling edge
  int n_req = 0, n_wait = 0;
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      if (rst) begin
        chk(ready === 1'b1, "R1 ready", int'(ready), 1);
        chk(slot_phase == 0 && line_slot == 0 && line_num == 0, "R1 counters",
            int'(slot_phase) + int'(line_slot) + int'(line_num), 0);
      end else begin : run
        int ep, es, el;
        bit rq;
        ep = cnt % ST;
        es = (cnt / ST) % LS;
        el = (cnt / (ST * LS)) % FL;
        rq = !mreq_n || !iorq_n;
        chk(int'(slot_phase) == ep, "R2 phase", int'(slot_phase), ep);
        chk(cpu_clk_en == ((ep % CD) == 0), "R3 cpu_clk_en", int'(cpu_clk_en), int'((ep % CD) == 0));
        chk(vid_fetch == (ep < HALF), "R4 vid_fetch", int'(vid_fetch), int'(ep < HALF));
        chk(ready == !(rq && ep < HALF), "R5 ready", int'(ready), int'(!(rq && ep < HALF)));
        chk(int'(line_slot) == es, "R7 line_slot", int'(line_slot), es);
        chk(line_strobe == (ep == ST-1 && es == LS-1), "R7 line_strobe",
            int'(line_strobe), int'(ep == ST-1 && es == LS-1));
        chk(int'(line_num) == el, "R8 line_num", int'(line_num), el);
        chk(frame_strobe == (ep == ST-1 && es == LS-1 && el == FL-1), "R8 frame_strobe",
            int'(frame_strobe), int'(ep == ST-1 && es == LS-1 && el == FL-1));
        if (line_strobe) lines_seen++;
        if (frame_strobe) frames_seen++;
        if (rq) begin
          n_req++;
          if (!ready) n_wait++;
        end
        if (cpu_done) begin
          if (!rq || q.size() == 0) chk(0, "R6 unexpected done", 1, 0);
          else begin : pop
            exp_t e;
            e = q.pop_front();
            chk(n_req == e.ticks, "R6 access length", n_req, e.ticks);
            chk(n_wait == e.waits, "R5 wait ticks", n_wait, e.waits);
            chk(int'(slot_phase) == ST-1, "R6 done phase", int'(slot_phase), ST-1);
          end
          n_req = 0;
          n_wait = 0;
        end
      end
    end
  end

  // driver: starts a request at bench phase s, holds it until completion
  task automatic issue(input int s, input bit mem, input bit io);
    exp_t e;
    @(negedge clk);
    while ((cnt % ST) != s) @(negedge clk);
    mreq_n = !mem;
    iorq_n = !io;
    e.ticks = ST - s;
    e.waits = (s < HALF) ? HALF - s : 0;
    q.push_back(e);
    forever begin
      #1;
      if (cpu_done) break;
      @(negedge clk);
    end
    @(negedge clk);
    mreq_n = 1'b1;
    iorq_n = 1'b1;
  endtask

  initial begin
    mreq_n = 1'b0;          // R1: request during reset must not stall
    repeat (4) @(negedge clk);
    mreq_n = 1'b1;
    rst = 1'b0;
    for (int s = 0; s < ST; s++) issue(s, 1'b1, 1'b0);
    for (int s = 0; s < ST; s++) issue(s, 1'b0, 1'b1);
    for (int s = ST - 1; s >= 0; s -= 3) issue(s, 1'b1, 1'b1);
    while (cnt < 3 * ST * LS * FL + 5) @(negedge clk);
    #2;
    chk(q.size() == 0, "R6 pending accesses", q.size(), 0);
    chk(frames_seen == cnt / (ST * LS * FL), "R8 frame count", frames_seen, cnt / (ST * LS * FL));
    chk(lines_seen == cnt / (ST * LS), "R7 line count", lines_seen, cnt / (ST * LS));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cnt, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule